// File: doc/BRIEF.md
# Serial audio port control and status register

This block is the 32-bit control and status word for one direction of a serial audio port. Software reaches it through a plain single-cycle register interface. A write strobe carries a full data word. The read data always shows the current contents, with no wait states.

The word holds several controls: per-flag interrupt enables, a DMA request enable, a port enable, a self-clearing FIFO reset command and a held software reset. It also shows five status flags. Three of them are sticky event flags:

- word start
- frame sync error
- FIFO error: underrun on a transmitter, overflow on a receiver

Software clears these by writing 1 to them. The other two flags follow live level inputs from the FIFO:

- FIFO warning: empty on a transmitter, full on a receiver
- FIFO request: the watermark has been reached

The block drives the interrupt line, the DMA request, a one-cycle FIFO reset pulse, the port enable seen by the serializer, and the port-wide reset.

Disabling the port does not take effect at once. The enable stays active, and reads back as 1, until the serializer reports that the frame in flight has ended. The external reset is asynchronous and active low. Inside the block it is released through a two-stage synchronizer, so the register starts responding on the third rising edge after the reset rises.

Top module: `audctl_csr`

## Requirements
- R1: After reset, the read word is 0 while both level inputs are low. Interrupt, DMA request, FIFO reset, port enable and port reset are all low.
- R2: Field positions are fixed:
  - bit 0: DMA request enable.
  - bits 8 to 12: interrupt enables.
  - bits 16 to 20: flags, with the flag at bit 16+i governed by the enable at bit 8+i. The order of i is 0 word start, 1 sync error, 2 FIFO error, 3 FIFO warning, 4 FIFO request.
  - bit 24: software reset.
  - bit 25: FIFO reset command.
  - bit 31: port enable.
- R3: A one-cycle pulse on an event input sets its sticky flag, which reads 1 after the next rising edge. The flag stays set with no further stimulus.
- R4: Writing 1 to a sticky flag bit clears it, and writing 0 leaves it unchanged. Writes to the two level flag bits have no effect.
- R5: An event pulse in the same cycle as a write-1-to-clear of its flag leaves the flag set.
- R6: The FIFO warning and FIFO request flags read the live state of their level inputs in the same cycle.
- R7: The interrupt is high exactly when at least one flag is 1 and its enable is 1. A flag whose enable is 0 does not raise it.
- R8: The DMA request is high only while the DMA request enable is 1 and the FIFO request input is high.
- R9: A write with bit 25 set produces a FIFO reset pulse one cycle long, starting after the write's edge. Bit 25 always reads 0.
- R10: A write with bit 24 set raises port reset and returns every enable and every sticky flag to 0 at that edge. While bit 24 is held, writes to other fields and event pulses are ignored, and the level flags read 0. A write of 0 to bit 24 releases the reset and leaves all fields at 0.
- R11: Writing 1 to bit 31 raises port enable and the bit 31 readback after that edge, and a frame-end pulse then has no effect. After a write of 0, both stay 1 until a frame-end pulse arrives; a pulse in the same cycle as the write also counts. Software reset clears them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| evt_word_start | input | 1 | Pulse: start of a word seen |
| evt_sync_err | input | 1 | Pulse: frame sync error |
| evt_fifo_err | input | 1 | Pulse: FIFO underrun (transmit) or overflow (receive) |
| lvl_fifo_warn | input | 1 | Level: FIFO empty (transmit) or full (receive) |
| lvl_fifo_req | input | 1 | Level: FIFO watermark reached |
| frame_done | input | 1 | Pulse: current frame has ended |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_rst | output | 1 | One-cycle FIFO reset pulse |
| port_en | output | 1 | Port enable to the serializer |
| port_rst | output | 1 | Port-wide software reset |

## Verification
The bench builds the block with its package defaults: three event flags, two level flags, and the field positions of R2. This places all five enable and flag pairs, together with the control bits, in one word. Every enable and flag pair can be driven and cleared alone or all together.

With these defaults, a write-1-to-clear can collide with an event in the same cycle. Software reset can be asserted while events, level inputs and a frame end are all active. A disable can be followed by a frame end that comes late, or by one that arrives in the same cycle as the write.

// File: rtl/audctl_pkg.sv
package audctl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned NUM_EVT  = 3;
  localparam int unsigned NUM_LVL  = 2;
  localparam int unsigned NUM_FLG  = NUM_EVT + NUM_LVL;

  // field positions in the word
  localparam int unsigned DMAE_POS = 0;
  localparam int unsigned IE_POS   = 8;
  localparam int unsigned FLG_POS  = 16;
  localparam int unsigned SR_POS   = 24;
  localparam int unsigned FR_POS   = 25;
  localparam int unsigned EN_POS   = 31;

  // flag indices (enable sits at IE_POS + idx, flag at FLG_POS + idx)
  localparam int unsigned FI_WSTART = 0;
  localparam int unsigned FI_SYNC   = 1;
  localparam int unsigned FI_FERR   = 2;
  localparam int unsigned FI_WARN   = 3;
  localparam int unsigned FI_REQ    = 4;
endpackage

// File: rtl/audctl_rst_sync.sv
module audctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/audctl_ctrl.sv
module audctl_ctrl
  import audctl_pkg::*;
#(
  parameter int unsigned NF = NUM_FLG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NF-1:0] wr_ie,
  input  logic          wr_dmae,
  input  logic          wr_sr,
  input  logic          wr_fr,
  output logic [NF-1:0] ie,
  output logic          dmae,
  output logic          sr_q,
  output logic          hold,
  output logic          fifo_rst
);
  logic [NF-1:0] ie_d;
  logic          dmae_d;
  logic          sr_d;
  logic          fr_d;
  logic          cfg_ld;

  // next-state logic
  always_comb begin
    hold   = sr_q | (wr_en & wr_sr);
    cfg_ld = hold | wr_en;
    sr_d   = wr_en ? wr_sr : sr_q;
    fr_d   = wr_en & wr_fr;
    if (hold) begin
      ie_d   = '0;
      dmae_d = 1'b0;
    end else begin
      ie_d   = wr_ie;
      dmae_d = wr_dmae;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= '0;
      dmae <= 1'b0;
    end else if (cfg_ld) begin
      ie   <= ie_d;
      dmae <= dmae_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else if (wr_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_rst <= 1'b0;
    else        fifo_rst <= fr_d;
  end
endmodule

// File: rtl/audctl_flags.sv
module audctl_flags
  import audctl_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT,
  parameter int unsigned NL = NUM_LVL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            lvl_mask,
  input  logic [NE-1:0]   evt_in,
  input  logic [NL-1:0]   lvl_in,
  input  logic            clr_wr,
  input  logic [NE-1:0]   clr_bits,
  output logic [NE+NL-1:0] flags
);
  for (genvar i = 0; i < NE; i++) begin : g_evt
    logic q;
    logic d;
    logic ld;

    always_comb begin
      ld = hold | evt_in[i] | (clr_wr & clr_bits[i]);
      if (hold)           d = 1'b0;
      else if (evt_in[i]) d = 1'b1;
      else                d = q & ~(clr_wr & clr_bits[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ld) q <= d;
    end

    assign flags[i] = q;
  end

  for (genvar j = 0; j < NL; j++) begin : g_lvl
    assign flags[NE+j] = lvl_in[j] & ~lvl_mask;
  end
endmodule

// File: rtl/audctl_enable.sv
module audctl_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic frame_done,
  output logic active
);
  logic req_q;
  logic req_d;
  logic act_d;

  always_comb begin
    if (hold)       req_d = 1'b0;
    else if (wr_en) req_d = wr_bit;
    else            req_d = req_q;

    if (hold)            act_d = 1'b0;
    else if (req_d)      act_d = 1'b1;
    else if (frame_done) act_d = 1'b0;
    else                 act_d = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      active <= 1'b0;
    end else begin
      req_q  <= req_d;
      active <= act_d;
    end
  end
endmodule

// File: rtl/audctl_csr.sv
module audctl_csr
  import audctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             evt_word_start,
  input  logic             evt_sync_err,
  input  logic             evt_fifo_err,
  input  logic             lvl_fifo_warn,
  input  logic             lvl_fifo_req,
  input  logic             frame_done,
  output logic             irq,
  output logic             dma_req,
  output logic             fifo_rst,
  output logic             port_en,
  output logic             port_rst
);
  logic               rst_sync_n;
  logic [NUM_FLG-1:0] ie;
  logic [NUM_FLG-1:0] flags;
  logic               dmae;
  logic               sr_q;
  logic               hold;
  logic               active;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_LVL-1:0] lvl_vec;
  logic               unused_wr;

  assign evt_vec   = {evt_fifo_err, evt_sync_err, evt_word_start};
  assign lvl_vec   = {lvl_fifo_req, lvl_fifo_warn};
  assign unused_wr = ^wr_data;

  audctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  audctl_ctrl #(.NF(NUM_FLG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_ie    (wr_data[IE_POS +: NUM_FLG]),
    .wr_dmae  (wr_data[DMAE_POS]),
    .wr_sr    (wr_data[SR_POS]),
    .wr_fr    (wr_data[FR_POS]),
    .ie       (ie),
    .dmae     (dmae),
    .sr_q     (sr_q),
    .hold     (hold),
    .fifo_rst (fifo_rst)
  );

  audctl_flags #(.NE(NUM_EVT), .NL(NUM_LVL)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hold     (hold),
    .lvl_mask (sr_q),
    .evt_in   (evt_vec),
    .lvl_in   (lvl_vec),
    .clr_wr   (wr_en),
    .clr_bits (wr_data[FLG_POS +: NUM_EVT]),
    .flags    (flags)
  );

  audctl_enable u_en (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hold       (hold),
    .wr_en      (wr_en),
    .wr_bit     (wr_data[EN_POS]),
    .frame_done (frame_done),
    .active     (active)
  );

  always_comb begin
    rd_data                       = '0;
    rd_data[DMAE_POS]             = dmae;
    rd_data[IE_POS +: NUM_FLG]    = ie;
    rd_data[FLG_POS +: NUM_FLG]   = flags;
    rd_data[SR_POS]               = sr_q;
    rd_data[EN_POS]               = active;
  end

  assign irq      = |(flags & ie);
  assign dma_req  = dmae & flags[FI_REQ];
  assign port_en  = active;
  assign port_rst = sr_q;
endmodule

// File: rtl/audctl_csr_chk.sv
module audctl_csr_chk
  import audctl_pkg::*;
(
  input logic             clk,
  input logic             rst_q_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             evt_word_start,
  input logic             evt_sync_err,
  input logic             evt_fifo_err,
  input logic             frame_done,
  input logic             irq,
  input logic             dma_req,
  input logic             fifo_rst,
  input logic             port_en,
  input logic             port_rst
);
  logic sr_write;
  assign sr_write = wr_en && wr_data[SR_POS];

  // R3 / R5: an event outside software reset always leaves its flag set
  a_r3_word_start_sets: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_word_start && !port_rst && !sr_write) |=> rd_data[FLG_POS+FI_WSTART]);
  a_r3_sync_err_sets: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_sync_err && !port_rst && !sr_write) |=> rd_data[FLG_POS+FI_SYNC]);
  a_r5_fifo_err_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_fifo_err && !port_rst && !sr_write) |=> rd_data[FLG_POS+FI_FERR]);

  // R4: writing 0 to a set sticky flag keeps it
  a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data[FLG_POS+FI_SYNC] && wr_en && !wr_data[FLG_POS+FI_SYNC] && !sr_write && !port_rst)
    |=> rd_data[FLG_POS+FI_SYNC]);

  // R7: with all enables clear there is no interrupt
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data[IE_POS +: NUM_FLG] == '0) |-> !irq);

  // R8: no DMA request without its enable
  a_r8_dma_gated: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_data[DMAE_POS] |-> !dma_req);

  // R9: FIFO reset command pulses and is never stored
  a_r9_fr_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_data[FR_POS]) |=> fifo_rst);
  a_r9_fr_cause: assert property (@(posedge clk) disable iff (!rst_q_n)
    fifo_rst |-> $past(wr_en && wr_data[FR_POS]));
  a_r9_fr_reads_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_data[FR_POS]);

  // R10: held software reset silences enables and outputs
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    port_rst |-> (!irq && !dma_req && !port_en && rd_data[IE_POS +: NUM_FLG] == '0));

  // R11: the port only drops after a frame end or a software reset
  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(port_en) |-> ($past(frame_done) || $past(port_rst) || $past(sr_write)));
endmodule

bind audctl_csr audctl_csr_chk u_chk (
  .clk            (clk),
  .rst_q_n        (rst_sync_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .evt_word_start (evt_word_start),
  .evt_sync_err   (evt_sync_err),
  .evt_fifo_err   (evt_fifo_err),
  .frame_done     (frame_done),
  .irq            (irq),
  .dma_req        (dma_req),
  .fifo_rst       (fifo_rst),
  .port_en        (port_en),
  .port_rst       (port_rst)
);

// File: tb/tb_audctl_csr.sv
module tb_audctl_csr;
  localparam logic [31:0] DMAE  = 32'h0000_0001;
  localparam logic [31:0] IE0   = 32'h0000_0100;
  localparam logic [31:0] IEALL = 32'h0000_1F00;
  localparam logic [31:0] FL0   = 32'h0001_0000;
  localparam logic [31:0] FL1   = 32'h0002_0000;
  localparam logic [31:0] FL2   = 32'h0004_0000;
  localparam logic [31:0] FL3   = 32'h0008_0000;
  localparam logic [31:0] FL4   = 32'h0010_0000;
  localparam logic [31:0] SRB   = 32'h0100_0000;
  localparam logic [31:0] FRB   = 32'h0200_0000;
  localparam logic [31:0] ENB   = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        evt_word_start, evt_sync_err, evt_fifo_err;
  logic        lvl_fifo_warn, lvl_fifo_req, frame_done;
  logic        irq, dma_req, fifo_rst, port_en, port_rst;

  always #5 clk = ~clk;

  audctl_csr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .evt_word_start(evt_word_start), .evt_sync_err(evt_sync_err), .evt_fifo_err(evt_fifo_err),
    .lvl_fifo_warn(lvl_fifo_warn), .lvl_fifo_req(lvl_fifo_req), .frame_done(frame_done),
    .irq(irq), .dma_req(dma_req), .fifo_rst(fifo_rst), .port_en(port_en), .port_rst(port_rst)
  );

  typedef struct {
    string       tag;
    logic [31:0] erd;
    logic [4:0]  eo;   // {irq, dma_req, fifo_rst, port_en, port_rst}
  } exp_t;

  exp_t sbq[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;

  // driver: one clock cycle of stimulus, optionally with an expectation
  task automatic cyc(input bit we, input logic [31:0] wd, input logic [2:0] ev,
                     input logic [1:0] lv, input bit fe, input bit chk,
                     input string tag, input logic [31:0] erd, input logic [4:0] eo);
    exp_t e;
    @(negedge clk);
    wr_en          = we;
    wr_data        = wd;
    evt_word_start = ev[0];
    evt_sync_err   = ev[1];
    evt_fifo_err   = ev[2];
    lvl_fifo_warn  = lv[0];
    lvl_fifo_req   = lv[1];
    frame_done     = fe;
    if (chk) begin
      e.tag = tag; e.erd = erd; e.eo = eo;
      sbq.push_back(e);
    end
    @(posedge clk);
  endtask

  // monitor: compares results shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sbq.size() > 0) begin
        exp_t e;
        logic [4:0] got;
        e   = sbq.pop_front();
        got = {irq, dma_req, fifo_rst, port_en, port_rst};
        n_tests++;
        if (rd_data !== e.erd || got !== e.eo) begin
          n_fail++;
          $display("FAIL %s: rd=%h out=%b expected rd=%h out=%b",
                   e.tag, rd_data, got, e.erd, e.eo);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run hung, R1..R11 checks incomplete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    evt_word_start = 1'b0; evt_sync_err = 1'b0; evt_fifo_err = 1'b0;
    lvl_fifo_warn = 1'b0; lvl_fifo_req = 1'b0; frame_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0, 0, "", 0, 0);

    cyc(0, 0,           0,      0,     0, 1, "R1 reset state",               0,              5'b00000);
    cyc(0, 0,           3'b001, 0,     0, 1, "R3 word start sets flag",      FL0,            5'b00000);
    cyc(0, 0,           0,      0,     0, 1, "R3 flag sticky",               FL0,            5'b00000);
    cyc(1, 0,           0,      0,     0, 1, "R4 write 0 keeps flag",        FL0,            5'b00000);
    cyc(1, IE0,         0,      0,     0, 1, "R7 enabled flag raises irq",   IE0|FL0,        5'b10000);
    cyc(1, IE0|FL0,     3'b001, 0,     0, 1, "R5 event beats clear",         IE0|FL0,        5'b10000);
    cyc(1, IE0|FL0,     0,      0,     0, 1, "R4 write 1 clears",            IE0,            5'b00000);
    cyc(0, 0,           3'b010, 0,     0, 1, "R7 masked flag no irq",        IE0|FL1,        5'b00000);
    cyc(1, IEALL,       0,      0,     0, 1, "R2 R7 all enables",            IEALL|FL1,      5'b10000);
    cyc(1, IEALL|FL1,   0,      0,     0, 1, "R4 clear sync error",          IEALL,          5'b00000);
    cyc(0, 0,           0,      2'b01, 0, 1, "R6 warn level live",           IEALL|FL3,      5'b10000);
    cyc(1, IEALL|FL3|FL4, 0,    2'b01, 0, 1, "R4 level flags ignore W1C",    IEALL|FL3,      5'b10000);
    cyc(0, 0,           0,      0,     0, 1, "R6 warn follows input",        IEALL,          5'b00000);
    cyc(0, 0,           0,      2'b10, 0, 1, "R8 request without enable",    IEALL|FL4,      5'b10000);
    cyc(1, IEALL|DMAE,  0,      2'b10, 0, 1, "R8 R2 dma request gated on",   IEALL|DMAE|FL4, 5'b11000);
    cyc(0, 0,           0,      0,     0, 1, "R8 dma follows request",       IEALL|DMAE,     5'b00000);
    cyc(0, 0,           3'b100, 0,     0, 1, "R3 fifo error flag",           IEALL|DMAE|FL2, 5'b10000);
    cyc(1, IEALL|DMAE|FRB, 0,   0,     0, 1, "R9 fifo reset pulse",          IEALL|DMAE|FL2, 5'b10100);
    cyc(0, 0,           0,      0,     0, 1, "R9 pulse single cycle",        IEALL|DMAE|FL2, 5'b10000);
    cyc(1, IEALL|DMAE|ENB, 0,   0,     0, 1, "R11 enable on",                IEALL|DMAE|FL2|ENB, 5'b10010);
    cyc(0, 0,           0,      0,     1, 1, "R11 frame end while enabled",  IEALL|DMAE|FL2|ENB, 5'b10010);
    cyc(1, IEALL|DMAE,  0,      0,     0, 1, "R11 disable drains",           IEALL|DMAE|FL2|ENB, 5'b10010);
    cyc(0, 0,           0,      0,     0, 1, "R11 still draining",           IEALL|DMAE|FL2|ENB, 5'b10010);
    cyc(0, 0,           0,      0,     1, 1, "R11 frame end stops port",     IEALL|DMAE|FL2, 5'b10000);
    cyc(1, SRB,         0,      0,     0, 1, "R10 soft reset clears",        SRB,            5'b00001);
    cyc(1, SRB|IEALL|DMAE|ENB|FL0, 3'b111, 2'b11, 1, 1, "R10 held reset ignores", SRB,       5'b00001);
    cyc(1, 0,           0,      0,     0, 1, "R10 release",                  0,              5'b00000);
    cyc(0, 0,           0,      2'b10, 0, 1, "R10 enables stay cleared",     FL4,            5'b00000);
    cyc(1, ENB,         0,      0,     0, 1, "R11 enable again",             ENB,            5'b00010);
    cyc(1, 0,           0,      0,     1, 1, "R11 disable with frame end",   0,              5'b00000);
    cyc(1, ENB,         0,      0,     0, 1, "R11 enable before reset",      ENB,            5'b00010);
    cyc(1, SRB,         0,      0,     0, 1, "R10 R11 reset drops enable",   SRB,            5'b00001);
    cyc(1, 0,           0,      0,     0, 1, "R10 released again",           0,              5'b00000);

    repeat (2) @(posedge clk);
    #4;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule